// File: doc/BRIEF.md
# Distributed DRAM Refresh Controller

This block makes sure that every row of a DRAM array is refreshed within its retention period. An interval timer counts system clocks. Each time it expires, the block owes refresh work, and it raises a request towards the access sequencer that owns the DRAM pins. When the access sequencer grants the request, the strobe sequencer takes the RAS and CAS lines and refreshes one whole row per row cycle. It keeps `busy` high until it has cleared all the work it owes.

Two strobe orderings are available, chosen for each grant by `cbr_sel`:

- **Row-address-only refresh.** The controller places a row number from its own counter on `row_addr` and pulses RAS while CAS stays high. The counter then moves on to the next row and wraps after the last row.
- **CAS-before-RAS refresh.** CAS falls first and stays low while RAS pulses. The DRAM selects the row from its own counter, so the controller counter is left alone.

A build parameter selects between two refresh modes:

- **Distributed mode.** Each interval owes a single row. With 2048 rows, a 1030-clock interval at 66 MHz is about 15.6 us, which covers the array in about 32 ms.
- **Burst mode.** Each interval owes a sweep of every row, performed back to back.

If the grant is late, the intervals that expire in the meantime are queued up to a limit. All queued work is then serviced in one busy window.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is applied and after reset is released, `ras_n` and `cas_n` are 1, `busy` and `ref_req` are 0, and `row_addr` is 0.
- R2: The first refresh is owed, and `ref_req` becomes 1, exactly INTERVAL clocks after reset is released. Further refreshes are owed every INTERVAL clocks after that.
- R3: A refresh starts only on a clock edge where `ref_req` and `ref_gnt` are both 1. On that edge `busy` becomes 1 and `ref_req` becomes 0. `ref_req` stays 0 while `busy` is 1. A `ref_gnt` while `ref_req` is 0 has no effect.
- R4: A row-address-only row lasts 1+T_RAS+T_PRE cycles:
  - one setup cycle with `ras_n`=1;
  - T_RAS cycles with `ras_n`=0;
  - T_PRE cycles with `ras_n`=1.
  
  `cas_n` stays 1 for the whole row, and `row_addr` holds the row being refreshed throughout.
- R5: `row_addr` increases by 1 after each row-address-only row. It wraps from ROWS-1 to 0.
- R6: In CAS-before-RAS refresh, `cas_n` is 0 from the setup cycle until the last row of the busy window ends, so CAS is low before every RAS fall. `row_addr` does not change.
- R7: `cbr_sel` is sampled on the grant edge only (1 = CAS-before-RAS, 0 = row-address-only). Changing it during the busy window has no effect.
- R8: Intervals that expire while refresh is owed and not yet granted are queued. On grant, all queued rows are refreshed back to back in one busy window, with `busy` held at 1.
- R9: At most PEND_MAX intervals are queued. Expiries beyond that are dropped.
- R10: With BURST=1, each interval owes ROWS rows. A grant refreshes them back to back in one busy window of ROWS*(1+T_RAS+T_PRE) cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbr_sel | input | 1 | Strobe ordering for the next grant: 1 = CAS-before-RAS, 0 = row-address-only |
| ref_gnt | input | 1 | Grant from the access sequencer |
| ref_req | output | 1 | Refresh owed and controller idle |
| busy | output | 1 | Controller owns the DRAM strobes |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | $clog2(ROWS) | Row number for row-address-only refresh |

## Verification
The main function is exercised with several input patterns, each of which separates different faults:

- **Table of single grants.** Row-address-only and CAS-before-RAS grants are mixed, and `cbr_sel` is flipped right after each grant. The strobe patterns, the counter advance and the wrap past the last row show whether the mode is latched correctly and whether only row-address-only rows step the counter.
- **Late grants.** Grants withheld for two and for five intervals separate correct queueing from lost or unbounded counting. The busy length and the number of RAS pulses are checked, along with CAS staying low through a queued CAS-before-RAS run.
- **Stray grant.** A grant with no request pending confirms that the handshake ignores it.
- **Burst build.** A second instance built for burst refresh shows that one interval yields a full sweep that returns the counter to its start.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SETUP = 2'd1,
    SQ_ACT   = 2'd2,
    SQ_PRE   = 2'd3
  } sq_state_e;
endpackage

// File: rtl/dref_interval_timer.sv
module dref_interval_timer #(
  parameter int INTERVAL = 1030
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CNT_W = $clog2(INTERVAL);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);

  // R2
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/dref_pending.sv
module dref_pending #(
  parameter int PEND_MAX = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic unit_done,
  input  logic busy,
  input  logic gnt,
  output logic req,
  output logic start,
  output logic more
);
  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam logic [PEND_W-1:0] CAP = PEND_W'(PEND_MAX);

  logic [PEND_W-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else begin
      case ({tick, unit_done})
        2'b10:   if (pend_q < CAP) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign req   = (pend_q != '0) && !busy;
  assign start = req && gnt;
  assign more  = (pend_q > PEND_W'(1)) || tick;

  // R9
  pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CAP);
  // R8
  owed_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_done |-> pend_q != '0);
endmodule

// File: rtl/dref_strobe_seq.sv
module dref_strobe_seq
  import dref_pkg::*;
#(
  parameter int ROWS  = 2048,
  parameter int T_RAS = 3,
  parameter int T_PRE = 2,
  parameter int UNIT  = 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    cbr_sel,
  input  logic                    more,
  output logic                    unit_done,
  output logic                    busy,
  output logic                    ras_n,
  output logic                    cas_n,
  output logic [$clog2(ROWS)-1:0] row_addr
);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int PH_TOP = (T_RAS > T_PRE) ? T_RAS : T_PRE;
  localparam int PH_W   = $clog2(PH_TOP + 1);
  localparam int UNIT_W = (UNIT > 1) ? $clog2(UNIT) : 1;

  sq_state_e         state_q;
  logic [PH_W-1:0]   ph_q;
  logic [UNIT_W-1:0] unit_q;
  logic [ROW_W-1:0]  row_q;
  logic              mode_q;
  logic              row_end, unit_last;

  assign row_end   = (state_q == SQ_PRE) && (ph_q == PH_W'(T_PRE - 1));
  assign unit_last = (unit_q == UNIT_W'(UNIT - 1));
  assign unit_done = row_end && unit_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      ph_q    <= '0;
      unit_q  <= '0;
      row_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: if (start) begin
          state_q <= SQ_SETUP;
          mode_q  <= cbr_sel;
          ph_q    <= '0;
          unit_q  <= '0;
        end
        SQ_SETUP: begin
          state_q <= SQ_ACT;
          ph_q    <= '0;
        end
        SQ_ACT: begin
          if (ph_q == PH_W'(T_RAS - 1)) begin
            state_q <= SQ_PRE;
            ph_q    <= '0;
          end else ph_q <= ph_q + 1'b1;
        end
        SQ_PRE: begin
          if (row_end) begin
            ph_q <= '0;
            if (!mode_q)
              row_q <= (row_q == ROW_W'(ROWS - 1)) ? '0 : row_q + 1'b1;
            unit_q  <= unit_last ? '0 : unit_q + 1'b1;
            state_q <= (!unit_last || more) ? SQ_SETUP : SQ_IDLE;
          end else ph_q <= ph_q + 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign ras_n    = (state_q != SQ_ACT);
  assign cas_n    = !(mode_q && busy);
  assign row_addr = row_q;

  // R4
  rasonly_cas_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !mode_q) |-> cas_n);
  // R6
  cbr_cas_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && mode_q) |-> ($past(cas_n) == 1'b0));
  // R4
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$past(ras_n)) |-> $stable(row_q));
  // R6
  cbr_row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |=> $stable(row_q));
  // R5
  row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(row_q) == ROW_W'(ROWS - 1)) && (row_q != $past(row_q))) |-> (row_q == '0));
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROWS     = 2048,
  parameter int INTERVAL = 1030,
  parameter int T_RAS    = 3,
  parameter int T_PRE    = 2,
  parameter int PEND_MAX = 7,
  parameter bit BURST    = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cbr_sel,
  input  logic                    ref_gnt,
  output logic                    ref_req,
  output logic                    busy,
  output logic                    ras_n,
  output logic                    cas_n,
  output logic [$clog2(ROWS)-1:0] row_addr
);
  localparam int UNIT = BURST ? ROWS : 1;

  logic tick, unit_done, start, more, busy_w;

  dref_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  dref_pending #(.PEND_MAX(PEND_MAX)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .unit_done(unit_done),
    .busy     (busy_w),
    .gnt      (ref_gnt),
    .req      (ref_req),
    .start    (start),
    .more     (more)
  );

  dref_strobe_seq #(.ROWS(ROWS), .T_RAS(T_RAS), .T_PRE(T_PRE), .UNIT(UNIT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cbr_sel  (cbr_sel),
    .more     (more),
    .unit_done(unit_done),
    .busy     (busy_w),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .row_addr (row_addr)
  );

  assign busy = busy_w;
endmodule

// File: tb/tb_dram_refresh_ctrl.sv
module tb_dram_refresh_ctrl;
  localparam int ROWS = 8;
  localparam int IVL  = 20;
  localparam int IVLB = 60;
  localparam int TRAS = 2;
  localparam int TPRE = 1;
  localparam int PMAX = 4;
  localparam int RCYC = 1 + TRAS + TPRE;

  // bit3 = cbr_sel, bits[2:0] = expected row_addr after the refresh
  localparam logic [3:0] VEC [11] = '{4'b0001, 4'b0010, 4'b1010, 4'b0011, 4'b0100,
                                      4'b0101, 4'b1101, 4'b0110, 4'b0111, 4'b0000, 4'b0001};

  logic clk = 1'b0;
  logic rst_n, cbr_sel, ref_gnt, ref_req, busy, ras_n, cas_n;
  logic [2:0] row_addr;
  logic rst_b, gnt_b, req_b, busy_b, ras_b, cas_b;
  logic [2:0] row_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dram_refresh_ctrl #(.ROWS(ROWS), .INTERVAL(IVL), .T_RAS(TRAS), .T_PRE(TPRE),
                      .PEND_MAX(PMAX), .BURST(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cbr_sel(cbr_sel), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .busy(busy), .ras_n(ras_n), .cas_n(cas_n), .row_addr(row_addr));

  dram_refresh_ctrl #(.ROWS(ROWS), .INTERVAL(IVLB), .T_RAS(TRAS), .T_PRE(TPRE),
                      .PEND_MAX(PMAX), .BURST(1'b1)) dut_burst (
    .clk(clk), .rst_n(rst_b), .cbr_sel(1'b0), .ref_gnt(gnt_b), .ref_req(req_b),
    .busy(busy_b), .ras_n(ras_b), .cas_n(cas_b), .row_addr(row_b));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_req();
    for (int n = 0; n < 4 * IVL && !ref_req; n++) @(negedge clk);
    chk("R2 request pending", int'(ref_req), 1);
  endtask

  task automatic service(input logic sel, output int cyc, output int pulses, output int cas_bad);
    logic prev;
    cyc = 0; pulses = 0; cas_bad = 0; prev = 1'b1;
    cbr_sel = sel;
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    while (busy && cyc < 300) begin
      if (!ras_n && prev) pulses++;
      prev = ras_n;
      if (cas_n != !sel) cas_bad++;
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc, pulses, cas_bad;
    logic [2:0] prev_row;
    logic sel;
    rst_n = 1'b0; rst_b = 1'b0; cbr_sel = 1'b0; ref_gnt = 1'b0; gnt_b = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 ras_n in reset", int'(ras_n), 1);
    chk("R1 cas_n in reset", int'(cas_n), 1);
    chk("R1 busy in reset", int'(busy), 0);
    chk("R1 req in reset", int'(ref_req), 0);
    chk("R1 row in reset", int'(row_addr), 0);
    rst_n = 1'b1;
    for (int k = 1; k <= IVL; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk("R1 busy after release", int'(busy), 0);
        chk("R1 ras_n after release", int'(ras_n), 1);
      end
      if (k == IVL - 1) chk("R2 req one clock early", int'(ref_req), 0);
      if (k == IVL) chk("R2 req at interval", int'(ref_req), 1);
    end

    // Table walk: per-cycle strobe shape, mode latch, row counter and wrap
    prev_row = 3'd0;
    for (int i = 0; i < 11; i++) begin
      sel = VEC[i][3];
      wait_req();
      cbr_sel = sel;
      ref_gnt = 1'b1;
      @(negedge clk);
      ref_gnt = 1'b0;
      cbr_sel = !sel; // R7: change after grant must not matter
      chk("R3 busy on grant", int'(busy), 1);
      chk("R3 req drops while busy", int'(ref_req), 0);
      chk("R4 setup ras_n high", int'(ras_n), 1);
      chk("R7 setup cas_n follows latched mode", int'(cas_n), int'(!sel));
      chk("R4 row held in setup", int'(row_addr), int'(prev_row));
      for (int j = 0; j < TRAS; j++) begin
        @(negedge clk);
        chk("R4 ras_n low phase", int'(ras_n), 0);
        chk("R6 cas_n during ras low", int'(cas_n), int'(!sel));
        chk("R4 row held while ras low", int'(row_addr), int'(prev_row));
      end
      for (int j = 0; j < TPRE; j++) begin
        @(negedge clk);
        chk("R4 precharge ras_n high", int'(ras_n), 1);
        chk("R4 busy in precharge", int'(busy), 1);
      end
      @(negedge clk);
      chk("R4 busy ends after row", int'(busy), 0);
      chk("R1 cas_n idle high", int'(cas_n), 1);
      chk(sel ? "R6 cbr leaves row" : "R5 row advance/wrap", int'(row_addr), int'(VEC[i][2:0]));
      prev_row = VEC[i][2:0];
    end

    // R3: grant with no request is ignored
    chk("R3 no req before stray grant", int'(ref_req), 0);
    ref_gnt = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R3 stray grant busy", int'(busy), 0);
      chk("R3 stray grant ras_n", int'(ras_n), 1);
    end
    ref_gnt = 1'b0;

    // R8: three queued CAS-before-RAS rows
    wait_req();
    repeat (2 * IVL) @(negedge clk);
    service(1'b1, cyc, pulses, cas_bad);
    chk("R8 queued busy cycles", cyc, 3 * RCYC);
    chk("R8 queued ras pulses", pulses, 3);
    chk("R6 cas low across queued rows", cas_bad, 0);
    chk("R6 queued cbr row unchanged", int'(row_addr), 1);

    // R9: six expiries, capped at four
    wait_req();
    repeat (5 * IVL) @(negedge clk);
    service(1'b0, cyc, pulses, cas_bad);
    chk("R9 capped busy cycles", cyc, PMAX * RCYC);
    chk("R9 capped ras pulses", pulses, PMAX);
    chk("R9 row after capped run", int'(row_addr), 5);
    chk("R4 cas high in row-only run", cas_bad, 0);

    // R10: burst build sweeps every row per interval
    rst_b = 1'b1;
    for (int n = 0; n < 2 * IVLB && !req_b; n++) @(negedge clk);
    chk("R10 burst request", int'(req_b), 1);
    gnt_b = 1'b1;
    @(negedge clk);
    gnt_b = 1'b0;
    begin
      logic pb;
      pb = 1'b1; cyc = 0; pulses = 0;
      while (busy_b && cyc < 300) begin
        if (!ras_b && pb) pulses++;
        pb = ras_b;
        cyc++;
        @(negedge clk);
      end
    end
    chk("R10 burst busy cycles", cyc, ROWS * RCYC);
    chk("R10 burst ras pulses", pulses, ROWS);
    chk("R10 burst row returns", int'(row_b), 0);
    chk("R10 burst req cleared", int'(req_b), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule